// File: doc/BRIEF.md
# Shadow Memory Attribute Router

This block decides, for every processor access that lands in the legacy window between 640 KB and 1 MB, whether main memory claims the cycle or the cycle goes out to the expansion bus. It also reports whether the access may be held in the first-level cache and in the second-level cache. The window is split into fourteen segments. One 128 KB segment covers A0000h–BFFFFh and one 64 KB segment covers F0000h–FFFFFh. Twelve 16 KB segments cover C0000h–EFFFFh. Each segment has three attribute bits: read enable, write enable and cache enable.

The attribute bits sit in seven byte-wide configuration registers on a simple register port. They all reset to zero. Because of this, after reset every access inside the window is forwarded to the bus. Firmware typically opens a segment as write-only and copies a bus-side ROM into the DRAM behind it. It then switches the segment to read-only or read/write. A segment that has cache enable set while read enable is clear is flagged as a configuration error, and it is never reported cacheable.

Each access gives a registered verdict one cycle after its strobe. A register write updates the attributes at the same edge that registers a concurrent access. That concurrent access is still judged with the old attributes.

Top module: `shadow_attr_router`

## Requirements
- R1: After reset, all seven attribute registers read 00h and `cfg_err` is all zero. Every read or write access inside A0000h–FFFFFh is answered with `rsp_fwd`=1, `rsp_mem`=0, `rsp_l1`=0 and `rsp_l2`=0.
- R2: The attribute registers are at configuration offsets 59h–5Fh. A write stores `cfg_wdata` with bits 3 and 7 forced to 0. A read returns the register contents on `cfg_rdata` in the cycle after `cfg_rd`, taken from before any write at that same edge. Reads of any other offset return 00h, and writes to any other offset change nothing. `cfg_rdata` is 00h in every cycle that does not follow a read.
- R3: The register at offset 59h controls two segments. Its bits [2:0] control A0000h–BFFFFh and its bits [6:4] control F0000h–FFFFFh. The register at offset 5Ah+j (j = 0..5) controls two 16 KB segments. Its bits [2:0] control the segment at C0000h + 32 KB·j, and its bits [6:4] control the segment at C4000h + 32 KB·j. Within each 3-bit field, bit 0 is read enable, bit 1 is write enable and bit 2 is cache enable.
- R4: A read inside the window is claimed by memory (`rsp_mem`=1) when its segment has read enable set. Otherwise it is forwarded (`rsp_fwd`=1).
- R5: A write inside the window is claimed by memory when its segment has write enable set. Otherwise it is forwarded.
- R6: `rsp_l1` is 1 inside the window only when the segment has cache enable and read enable set, and one of these holds: write enable is set, or the access is a code-fetch read (`acc_write`=0, `acc_code`=1).
- R7: `rsp_l2` is 1 inside the window only when cache enable, read enable and write enable are all set. A read-only segment is never L2-cacheable.
- R8: `cfg_err` bit n is 1 while segment n has cache enable=1 and read enable=0. It updates at the same edge as the register write. Segment n is the field at bit 4·(n mod 2) of register 59h + n/2. A segment in that state is never reported cacheable.
- R9: Accesses below A0000h, or at 100000h and above, ignore the attributes. They give `rsp_mem`=1, `rsp_fwd`=0, `rsp_l1`=1 and `rsp_l2`=1.
- R10: `rsp_valid` is 1 exactly in the cycle after `acc_valid`. When `rsp_valid` is 0, all four verdict outputs are 0. An access presented together with a register write is judged with the attributes from before that write.
- R11: Whenever `rsp_valid` is 1, exactly one of `rsp_mem` and `rsp_fwd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data, one cycle after `cfg_rd` |
| acc_valid | input | 1 | Processor access strobe |
| acc_addr | input | ADDR_W | Processor byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_code | input | 1 | Read is an instruction fetch |
| rsp_valid | output | 1 | Verdict valid |
| rsp_mem | output | 1 | Main memory claims the access |
| rsp_fwd | output | 1 | Access is forwarded to the expansion bus |
| rsp_l1 | output | 1 | Access may be cached in L1 |
| rsp_l2 | output | 1 | Access may be cached in L2 |
| cfg_err | output | 2·NUM_REGS | Per-segment illegal-setting flags |

## Verification
The case that is hardest to reach from the ports is the overlap between a register write and an access to the segment that the write changes. The access must be judged with the attributes from before the write. The error flag must still change at the same edge. The bench drives `cfg_wr` and `acc_valid` in the same cycle on purpose, with the access aimed at the segment being rewritten. It also runs a long stretch of random configuration traffic mixed with accesses, which reaches all eight attribute combinations in every segment. Among them are the illegal cache-without-read settings and code-fetch versus data reads on read-only segments.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

    // Attribute field of one segment (bit 0 read, bit 1 write, bit 2 cache)
    typedef struct packed {
        logic ce;
        logic we;
        logic re;
    } seg_attr_t;

    // Registered verdict for one access
    typedef struct packed {
        logic valid;
        logic mem;
        logic fwd;
        logic l1;
        logic l2;
    } route_t;

    localparam int unsigned FIELD_W = 4;   // nibble per segment
    localparam logic [7:0]  REG_WMASK = 8'h77;

endpackage

// File: rtl/attr_regfile.sv
module attr_regfile
    import shadow_attr_pkg::*;
#(
    parameter int              NUM_REGS = 7,
    parameter int              CFG_AW   = 8,
    parameter logic [CFG_AW-1:0] CFG_BASE = 8'h59
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_wr,
    input  logic                    cfg_rd,
    input  logic [CFG_AW-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output logic [7:0]              rdata,
    output logic [NUM_REGS*8-1:0]   regs_q_o,
    output logic [NUM_REGS*8-1:0]   regs_d_o
);
    localparam int REG_BITS = NUM_REGS * 8;
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    typedef struct packed {
        logic [REG_BITS-1:0] regs;
        logic [7:0]          rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [CFG_AW-1:0] rel;
    logic              hit;
    logic [IDX_W-1:0]  idx;

    always_comb begin
        rel  = cfg_addr - CFG_BASE;
        hit  = (cfg_addr >= CFG_BASE) && (rel < CFG_AW'(NUM_REGS));
        idx  = IDX_W'(rel);
        st_d = st_q;
        st_d.rdata = 8'h00;
        if (cfg_rd && hit) begin
            st_d.rdata = st_q.regs[idx*8 +: 8];
        end
        if (cfg_wr && hit) begin
            st_d.regs[idx*8 +: 8] = cfg_wdata & REG_WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign regs_q_o = st_q.regs;
    assign regs_d_o = st_d.regs;

endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
    parameter int ADDR_W = 32,
    parameter int NSEG   = 14,
    localparam int SEG_W = $clog2(NSEG)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [SEG_W-1:0]  seg_idx
);
    logic       hi_zero;
    logic [5:0] blk16k;
    logic       unused_low;

    assign unused_low = ^addr[13:0];

    always_comb begin
        hi_zero = (addr[ADDR_W-1:20] == '0);
        blk16k  = addr[19:14];
        in_win  = 1'b0;
        seg_idx = '0;
        if (hi_zero) begin
            if (addr[19:17] == 3'b101) begin
                // A0000h-BFFFFh, one 128 KB segment
                in_win  = 1'b1;
                seg_idx = SEG_W'(0);
            end else if (addr[19:16] == 4'hF) begin
                // F0000h-FFFFFh, one 64 KB segment
                in_win  = 1'b1;
                seg_idx = SEG_W'(1);
            end else if (addr[19:18] == 2'b11) begin
                // C0000h-EFFFFh, twelve 16 KB segments
                in_win  = 1'b1;
                seg_idx = SEG_W'(blk16k - 6'h30) + SEG_W'(2);
            end
        end
    end

endmodule

// File: rtl/attr_policy.sv
module attr_policy
    import shadow_attr_pkg::*;
(
    input  logic      valid,
    input  logic      in_win,
    input  seg_attr_t attr,
    input  logic      is_write,
    input  logic      is_code,
    output route_t    route
);
    logic legal;

    always_comb begin
        route = '0;
        legal = !(attr.ce && !attr.re);
        if (valid) begin
            route.valid = 1'b1;
            if (!in_win) begin
                route.mem = 1'b1;
                route.l1  = 1'b1;
                route.l2  = 1'b1;
            end else begin
                route.mem = is_write ? attr.we : attr.re;
                route.fwd = !route.mem;
                route.l1  = legal && attr.ce && attr.re &&
                            (attr.we || (!is_write && is_code));
                route.l2  = legal && attr.ce && attr.re && attr.we;
            end
        end
    end

endmodule

// File: rtl/shadow_attr_router.sv
module shadow_attr_router
    import shadow_attr_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         NUM_REGS = 7,
    parameter logic [7:0] CFG_BASE = 8'h59,
    localparam int        NSEG     = 2 * NUM_REGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_rd,
    input  logic [7:0]        cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_code,
    output logic              rsp_valid,
    output logic              rsp_mem,
    output logic              rsp_fwd,
    output logic              rsp_l1,
    output logic              rsp_l2,
    output logic [NSEG-1:0]   cfg_err
);
    localparam int SEG_W    = $clog2(NSEG);
    localparam int REG_BITS = NUM_REGS * 8;

    typedef struct packed {
        route_t            rsp;
        logic [NSEG-1:0]   err;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [REG_BITS-1:0] regs_q;
    logic [REG_BITS-1:0] regs_d;
    logic                in_win;
    logic [SEG_W-1:0]    seg_idx;
    seg_attr_t           attr;
    route_t              route;
    logic [NSEG-1:0]     err_next;
    logic                unused_regs;

    assign unused_regs = ^regs_d;

    attr_regfile #(
        .NUM_REGS (NUM_REGS),
        .CFG_AW   (8),
        .CFG_BASE (CFG_BASE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_rd    (cfg_rd),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .rdata     (cfg_rdata),
        .regs_q_o  (regs_q),
        .regs_d_o  (regs_d)
    );

    seg_decode #(
        .ADDR_W (ADDR_W),
        .NSEG   (NSEG)
    ) u_dec (
        .addr    (acc_addr),
        .in_win  (in_win),
        .seg_idx (seg_idx)
    );

    // Attributes of the addressed segment, taken from the pre-write bank
    always_comb begin
        attr = seg_attr_t'(regs_q[seg_idx*FIELD_W +: 3]);
    end

    attr_policy u_pol (
        .valid    (acc_valid),
        .in_win   (in_win),
        .attr     (attr),
        .is_write (acc_write),
        .is_code  (acc_code),
        .route    (route)
    );

    // Illegal-setting flags follow the bank's next contents
    for (genvar n = 0; n < NSEG; n++) begin : g_err
        assign err_next[n] = regs_d[n*FIELD_W + 2] && !regs_d[n*FIELD_W];
    end

    always_comb begin
        st_d     = st_q;
        st_d.rsp = route;
        st_d.err = err_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp.valid;
    assign rsp_mem   = st_q.rsp.mem;
    assign rsp_fwd   = st_q.rsp.fwd;
    assign rsp_l1    = st_q.rsp.l1;
    assign rsp_l2    = st_q.rsp.l2;
    assign cfg_err   = st_q.err;

endmodule

// File: rtl/shadow_attr_router_chk.sv
module shadow_attr_router_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              rsp_valid,
    input logic              rsp_mem,
    input logic              rsp_fwd,
    input logic              rsp_l1,
    input logic              rsp_l2
);
    logic outside;
    assign outside = (acc_addr < ADDR_W'(32'h000A_0000)) ||
                     (acc_addr >= ADDR_W'(32'h0010_0000));

    a_r11_single_route: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $onehot({rsp_mem, rsp_fwd}));

    a_r10_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !(rsp_mem || rsp_fwd || rsp_l1 || rsp_l2));

    a_r6_l1_needs_memory: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_l1 |-> rsp_mem);

    a_r7_l2_needs_l1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_l2 |-> rsp_l1);

    a_r9_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && outside) |=> (rsp_mem && rsp_l1 && rsp_l2 && !rsp_fwd));

endmodule

bind shadow_attr_router shadow_attr_router_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .rsp_valid (rsp_valid),
    .rsp_mem   (rsp_mem),
    .rsp_fwd   (rsp_fwd),
    .rsp_l1    (rsp_l1),
    .rsp_l2    (rsp_l2)
);

// File: tb/shadow_attr_router_bench.sv
`timescale 1ns/1ps
module shadow_attr_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [7:0]  cfg_addr = 8'h00, cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        acc_valid = 1'b0, acc_write = 1'b0, acc_code = 1'b0;
    logic [31:0] acc_addr = 32'h0;
    logic        rsp_valid, rsp_mem, rsp_fwd, rsp_l1, rsp_l2;
    logic [13:0] cfg_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string phase = "R1 reset";
    int mregs[7];

    always #4 clk = ~clk;   // 125 MHz

    shadow_attr_router u_shadow_attr_router (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_code(acc_code),
        .rsp_valid(rsp_valid), .rsp_mem(rsp_mem), .rsp_fwd(rsp_fwd),
        .rsp_l1(rsp_l1), .rsp_l2(rsp_l2), .cfg_err(cfg_err)
    );

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s] act=%0h exp=%0h", tag, what, phase, act, exp);
        end
    endtask

    function automatic int seg_of(logic [31:0] a);
        if (a < 32'hA0000 || a >= 32'h100000) return -1;
        if (a < 32'hC0000) return 0;
        if (a >= 32'hF0000) return 1;
        return 2 + int'((a - 32'hC0000) >> 14);
    endfunction

    function automatic int field_of(int s);
        return (mregs[s / 2] >> (4 * (s % 2))) & 7;
    endfunction

    // One clock: predict from current inputs and pre-edge model, then compare
    task automatic step();
        int  s, f, off;
        bit  re, we, ce, e_mem, e_l1, e_l2, e_v, inr;
        int  e_rd, e_err;
        string rtag;
        e_v = acc_valid; e_mem = 0; e_l1 = 0; e_l2 = 0;
        s = seg_of(acc_addr);
        rtag = (s < 0) ? "R9" : (acc_write ? "R5" : "R4");
        if (acc_valid) begin
            if (s < 0) begin
                e_mem = 1; e_l1 = 1; e_l2 = 1;
            end else begin
                f = field_of(s);
                re = f[0]; we = f[1]; ce = f[2];
                e_mem = acc_write ? we : re;
                e_l1  = ce && re && (we || (!acc_write && acc_code));
                e_l2  = ce && re && we;
            end
        end
        off = int'(cfg_addr) - 'h59;
        inr = (off >= 0 && off < 7);
        e_rd = (cfg_rd && inr) ? mregs[off] : 0;
        if (cfg_wr && inr) mregs[off] = int'(cfg_wdata) & 'h77;
        e_err = 0;
        for (int n = 0; n < 14; n++) begin
            f = field_of(n);
            if (f[2] && !f[0]) e_err |= (1 << n);
        end
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == e_v, "R10", "rsp_valid", rsp_valid, e_v);
        chk(rsp_mem == e_mem, e_v ? rtag : "R10", "rsp_mem", rsp_mem, e_mem);
        chk(rsp_fwd == (e_v && !e_mem), e_v ? rtag : "R10", "rsp_fwd", rsp_fwd, e_v && !e_mem);
        chk(rsp_l1 == e_l1, "R6", "rsp_l1", rsp_l1, e_l1);
        chk(rsp_l2 == e_l2, "R7", "rsp_l2", rsp_l2, e_l2);
        chk(int'(cfg_rdata) == e_rd, "R2", "cfg_rdata", cfg_rdata, e_rd);
        chk(int'(cfg_err) == e_err, "R8", "cfg_err", cfg_err, e_err);
        if (rsp_valid) chk((rsp_mem ^ rsp_fwd) == 1'b1, "R11", "one route", {rsp_mem, rsp_fwd}, 0);
    endtask

    task automatic idle();
        cfg_wr = 0; cfg_rd = 0; acc_valid = 0; acc_write = 0; acc_code = 0;
    endtask

    task automatic wr_reg(int off, int data);
        idle(); cfg_wr = 1; cfg_addr = 8'(off); cfg_wdata = 8'(data); step(); idle();
    endtask

    task automatic rd_reg(int off);
        idle(); cfg_rd = 1; cfg_addr = 8'(off); step(); idle();
    endtask

    task automatic access(logic [31:0] a, bit w, bit c);
        idle(); acc_valid = 1; acc_addr = a; acc_write = w; acc_code = c; step(); idle();
    endtask

    function automatic logic [31:0] seg_base(int s);
        if (s == 0) return 32'hA0000;
        if (s == 1) return 32'hF0000;
        return 32'hC0000 + 32'((s - 2) * 'h4000);
    endfunction

    function automatic logic [31:0] seg_last(int s);
        if (s == 0) return 32'hBFFFF;
        if (s == 1) return 32'hFFFFF;
        return seg_base(s) + 32'h3FFF;
    endfunction

    initial begin
        for (int i = 0; i < 7; i++) mregs[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state at the ports
        chk(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
        chk(cfg_err == 0, "R1", "cfg_err after reset", cfg_err, 0);
        chk(cfg_rdata == 0, "R1", "cfg_rdata after reset", cfg_rdata, 0);
        for (int i = 0; i < 7; i++) rd_reg('h59 + i);
        access(32'hA0000, 0, 0); access(32'hC8000, 1, 0);
        access(32'hE4000, 0, 1); access(32'hFFFFF, 0, 0);

        phase = "R2 register port";
        for (int i = 0; i < 7; i++) wr_reg('h59 + i, 'hFF);
        for (int i = 0; i < 7; i++) rd_reg('h59 + i);
        wr_reg('h58, 'h5A); wr_reg('h60, 'hA5);
        rd_reg('h58); rd_reg('h60); rd_reg('h59); rd_reg('h5F);
        idle(); cfg_rd = 1; cfg_wr = 1; cfg_addr = 8'h5C; cfg_wdata = 8'h12; step(); idle();
        rd_reg('h5C);

        phase = "R3 segment map";
        for (int s = 0; s < 14; s++) begin
            for (int i = 0; i < 7; i++) wr_reg('h59 + i, 0);
            wr_reg('h59 + s / 2, 3 << (4 * (s % 2)));
            for (int p = 0; p < 14; p++) begin
                access(seg_base(p), 0, 0);
                access(seg_last(p), 1, 0);
            end
        end

        phase = "R6 R7 attribute combinations";
        for (int v = 0; v < 8; v++) begin
            wr_reg('h5D, v | (v << 4));
            access(32'hD0000, 0, 0); access(32'hD0000, 0, 1);
            access(32'hD7FFF, 1, 0); access(32'hD4010, 1, 1);
        end

        phase = "R8 illegal cache without read";
        wr_reg('h59, 'h46); wr_reg('h5E, 'h04);
        access(32'hB0000, 0, 1); access(32'hF8000, 1, 0);
        access(32'hE0000, 0, 1);
        wr_reg('h5E, 'h05); access(32'hE0000, 0, 1);

        phase = "R9 outside window";
        access(32'h0, 0, 0); access(32'h9FFFF, 1, 0);
        access(32'h100000, 0, 1); access(32'hFFFFFFFF, 1, 1);

        phase = "R10 write and access together";
        wr_reg('h5B, 'h00);
        idle(); cfg_wr = 1; cfg_addr = 8'h5B; cfg_wdata = 8'h07;
        acc_valid = 1; acc_addr = 32'hC8000; step(); idle();
        access(32'hC8000, 0, 0);
        idle(); cfg_wr = 1; cfg_addr = 8'h5B; cfg_wdata = 8'h04;
        acc_valid = 1; acc_addr = 32'hC8100; acc_write = 1; step(); idle();
        access(32'hC8000, 0, 1);

        phase = "R4 R5 random traffic";
        for (int k = 0; k < 4000; k++) begin
            int sel;
            idle();
            sel = $urandom_range(0, 9);
            if (sel < 3) begin
                cfg_wr = 1; cfg_addr = 8'($urandom_range('h57, 'h61));
                cfg_wdata = 8'($urandom_range(0, 255));
            end else if (sel == 3) begin
                cfg_rd = 1; cfg_addr = 8'($urandom_range('h57, 'h61));
            end
            if ($urandom_range(0, 3) != 0) begin
                acc_valid = 1;
                acc_write = 1'($urandom_range(0, 1));
                acc_code  = 1'($urandom_range(0, 1));
                if ($urandom_range(0, 7) == 0)
                    acc_addr = $urandom();
                else
                    acc_addr = 32'hA0000 + 32'($urandom_range(0, 'h5FFFF));
            end
            step();
        end
        idle(); step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule